// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides an incoming clock by a programmable integer N. It does this with a dual-modulus prescaler followed by a main counter and a swallow counter. The prescaler base modulus P can be 8, 16 or 32. While the swallow counter is nonzero, the prescaler divides by P+1. Once the swallow counter has expired, it divides by P. A full period spans B prescaler cycles, so the total division is N = P·B + A. At the end of each period the block emits one single-cycle pulse. That pulse is meant to feed a phase/frequency detector.

The prescaler is modelled as ordinary synchronous logic that runs on the input clock. The two counters advance only on the cycle in which the prescaler completes a count. All settings are sampled when a period starts, so a change made part-way through a period never yields a shortened or lengthened period. A power-down input freezes the chain and holds it in its start state. A combinational error output marks settings that fall outside the pulse-swallow rules.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst` is high, `div_pulse` is low. The first pulse appears exactly N input cycles after `rst` falls, and later pulses follow every N cycles.
- R2: `psel` code 0 selects P=8, code 1 selects P=16 and code 2 selects P=32. With A ≤ B, the pulse period is P·B + A input cycles.
- R3: `div_pulse` is high for exactly one input cycle per period.
- R4: When A > B, the prescaler stays at P+1 for the whole period, so the period is B·(P+1).
- R5: `cfg_err` is high exactly when any of the following holds: A > B, A ≥ P, or `psel` = 3. Code 3 otherwise behaves as P=32.
- R6: For every N from P·(P−1) upward (56, 240 and 992 for the three moduli), the settings B = N div P and A = N mod P give `cfg_err` low and a period of N.
- R7: While `pwr_dn` is high, no pulse is produced. After `pwr_dn` falls, the first pulse comes N cycles later.
- R8: Changes to `psel`, `b_val` or `a_val` made during a period leave that period's length unchanged. They take effect from the next period.
- R9: B = 0 is treated as B = 1. With A = 0, the period is then P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | Holds the divider idle with no output pulses |
| psel | input | 2 | Prescaler modulus select: 0→8/9, 1→16/17, 2→32/33 |
| b_val | input | B_W | Main counter value B |
| a_val | input | A_W | Swallow counter value A |
| div_pulse | output | 1 | One-cycle pulse at the end of each N-cycle period |
| cfg_err | output | 1 | Current settings break the pulse-swallow rules |

## Verification
The bench builds the block at its default widths of 13 bits for B and 5 bits for A, so every prescaler code and the full swallow range are available. B is kept small enough that periods stay below a few thousand cycles. This brings the three lower ends of the continuous range (56, 240 and 992) within reach, together with the A > B, A ≥ P, B = 0 and reserved-code cases. Many randomly drawn settings can be measured over two consecutive periods each. Directed runs also cover a mid-period setting change and a power-down window.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int B_W = 13,
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_dn,
  input  logic [1:0]     psel,
  input  logic [B_W-1:0] b_val,
  input  logic [A_W-1:0] a_val,
  output logic           div_pulse,
  output logic           cfg_err
);

  localparam int PC_W = 6;

  function automatic logic [PC_W-1:0] base_mod(input logic [1:0] s);
    case (s)
      2'd0:    return PC_W'(8);
      2'd1:    return PC_W'(16);
      default: return PC_W'(32);
    endcase
  endfunction

  logic [PC_W-1:0] p_cur, pcnt;
  logic [B_W-1:0]  bcnt;
  logic [A_W-1:0]  acnt, a_cur;

  wire [B_W-1:0] b_eff   = (b_val == '0) ? B_W'(1) : b_val;
  wire           swallow = (acnt != '0);
  wire           pre_end = swallow ? (pcnt == p_cur) : (pcnt == p_cur - 1'b1);
  wire           last    = pre_end && (bcnt == B_W'(1));

  assign cfg_err = (int'(a_val) > int'(b_val)) ||
                   (int'(a_val) >= int'(base_mod(psel))) ||
                   (psel == 2'd3);

  always_ff @(posedge clk) begin
    if (rst || pwr_dn || last) begin
      pcnt  <= '0;
      bcnt  <= b_eff;
      acnt  <= a_val;
      a_cur <= a_val;
      p_cur <= base_mod(psel);
    end else if (pre_end) begin
      pcnt <= '0;
      bcnt <= bcnt - 1'b1;
      if (swallow) acnt <= acnt - 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
    div_pulse <= !(rst || pwr_dn) && last;
  end

  assert_one_wide_R3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  assert_quiet_pd_R7: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> !div_pulse);

  assert_pcnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    pcnt <= p_cur);

  assert_swallow_bound_R4: assert property (@(posedge clk) disable iff (rst)
    acnt <= a_cur);

  assert_pulse_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (pcnt == '0 && acnt == a_cur));

endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
  localparam int B_W = 13;
  localparam int A_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn = 1'b0;
  logic [1:0] psel = 2'd0;
  logic [B_W-1:0] b_val = '0;
  logic [A_W-1:0] a_val = '0;
  logic div_pulse, cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_swallow_div #(.B_W(B_W), .A_W(A_W)) dut (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .psel(psel),
    .b_val(b_val), .a_val(a_val), .div_pulse(div_pulse), .cfg_err(cfg_err));

  function automatic int pval(input int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : 32;
  endfunction

  function automatic int exp_period(input int s, input int b, input int a);
    int eb = (b == 0) ? 1 : b;
    if (a > eb) return eb * (pval(s) + 1);
    return pval(s) * eb + a;
  endfunction

  function automatic bit exp_err(input int s, input int b, input int a);
    return (a > b) || (a >= pval(s)) || (s == 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (div_pulse) break;
      if (n > 20000) break;
    end
  endtask

  task automatic setup(input int s, input int b, input int a);
    @(negedge clk);
    rst = 1'b1; psel = 2'(s); b_val = B_W'(b); a_val = A_W'(a);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_cfg(input string req, input int s, input int b, input int a);
    int g;
    setup(s, b, a);
    check({req, " err"}, int'(cfg_err), int'(exp_err(s, b, a)));
    gap(g);
    check({req, " first period"}, g, exp_period(s, b, a));
    @(negedge clk);
    check("R3 pulse width", int'(div_pulse), 0);
    g = 1;
    while (!div_pulse && g < 20000) begin @(negedge clk); g++; end
    check({req, " second period"}, g, exp_period(s, b, a));
  endtask

  initial begin
    int g, s, b, a, n;
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset pulse low", int'(div_pulse), 0);

    run_cfg("R1 R2 P8", 0, 5, 3);
    run_cfg("R2 P16", 1, 10, 7);
    run_cfg("R2 P32", 2, 4, 2);
    run_cfg("R4 A>B", 1, 3, 9);
    run_cfg("R5 A>=P", 0, 20, 8);
    run_cfg("R5 reserved code", 3, 3, 1);
    run_cfg("R9 B zero", 1, 0, 0);
    run_cfg("R9 B zero A one", 2, 0, 1);

    for (int k = 0; k < 3; k++) begin
      int p = pval(k);
      for (int j = 0; j < 3; j++) begin
        n = p * (p - 1) + j * 7;
        run_cfg("R6 continuous", k, n / p, n % p);
      end
    end

    for (int k = 0; k < 20; k++) begin
      s = int'($urandom_range(0, 3));
      b = int'($urandom_range(0, 40));
      a = int'($urandom_range(0, 31));
      run_cfg("R2 R4 R5 random", s, b, a);
    end

    setup(0, 6, 2);
    gap(g);
    check("R8 baseline", g, exp_period(0, 6, 2));
    g = 0;
    repeat (5) begin @(negedge clk); g++; end
    psel = 2'd1; b_val = B_W'(9); a_val = A_W'(4);
    while (!div_pulse && g < 20000) begin @(negedge clk); g++; end
    check("R8 period unchanged", g, exp_period(0, 6, 2));
    gap(g);
    check("R8 new period", g, exp_period(1, 9, 4));

    setup(1, 7, 3);
    repeat (10) @(negedge clk);
    pwr_dn = 1'b1;
    g = 0;
    repeat (400) begin @(negedge clk); if (div_pulse) g++; end
    check("R7 no pulses in power-down", g, 0);
    pwr_dn = 1'b0;
    gap(g);
    check("R7 period after release", g, exp_period(1, 7, 3));

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule